// File: doc/BRIEF.md
# Dual-Slope Current Trim Engine

This block sets two 10-bit analog trim codes of a dual-slope converter without software help. One code sizes the discharge current sink. The other sizes the input transconductor. The block does not measure anything itself. It borrows the converter's own conversion sequencer through a one-cycle start pulse and a done pulse, and it reads back the 13-bit discharge count and an overflow flag. A mode output tells the sequencer what to measure. Mode 0 means a forced full-scale capacitor discharge. Mode 1 means a conversion of the internal bandgap channel.

A run starts with a one-cycle request. The discharge code is settled first. It is found by a ten-step binary search, most significant bit first, starting from mid-scale (512). Each trial count is judged against the full-scale target. The transconductor code is searched next, in the same way, with the freshly found discharge code applied and the bandgap count judged against the bandgap target. Both targets sit in small registers that reset to 4095 and 2457. Each can be reloaded through a write strobe. At the end of a run both results move into holding registers together. A done pulse and a fail flag report the outcome. The reset input is assumed to be already released synchronously to `clk` at chip level.

Top module: `dsc_trim_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o` and `seq_start_o` are 0, and both `id_trim_o` and `gm_trim_o` equal 512.
- R2: A `cal_start_i` high while idle makes `busy_o` high from the next cycle. `busy_o` stays high until the run completes. `done_o` is a one-cycle pulse in the first cycle in which `busy_o` is low again.
- R3: A run issues exactly 20 one-cycle `seq_start_o` pulses, at most one per outstanding conversion. The first 10 carry `seq_mode_o`=0 (full-scale discharge) and the last 10 carry `seq_mode_o`=1 (bandgap conversion).
- R4: Each code is searched from 512, deciding bit 9 down to bit 0. At each step the bit under test is kept or cleared and the next lower bit is set. The result is the largest code for which the step's keep condition holds, or 0 if it holds for none.
- R5: In the discharge loop a bit is kept when the count is greater than or equal to the full-scale target, meaning the current is too low or exact.
- R6: In the transconductor loop a bit is kept when there is no overflow and the count is less than or equal to the bandgap target. A count above the target means the transconductance is too high.
- R7: `seq_ovf_i`=1 with `seq_done_i` counts as a count above the target in both loops, whatever `seq_count_i` holds.
- R8: The full-scale target resets to 4095 and the bandgap target to 2457. `fs_tgt_we_i` or `bg_tgt_we_i` loads `tgt_data_i` into the respective target.
- R9: During the discharge loop `id_trim_o` shows the trial code and `gm_trim_o` keeps its held value. During the transconductor loop `id_trim_o` shows the found discharge code and `gm_trim_o` the trial code. Outside a run both show holding registers, which change only at the end of a run.
- R10: `fail_o` is set at the end of a run when either final code is 0 or 1023 (search ran to a rail). It is cleared when the next run starts.
- R11: `cal_start_i` while a run is in progress is ignored. The run keeps its 20 conversions and its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start_i | input | 1 | Request a calibration run |
| fs_tgt_we_i | input | 1 | Load full-scale target from `tgt_data_i` |
| bg_tgt_we_i | input | 1 | Load bandgap target from `tgt_data_i` |
| tgt_data_i | input | 13 | Target value to load |
| seq_start_o | output | 1 | One-cycle conversion request to the sequencer |
| seq_mode_o | output | 1 | 0: forced full-scale discharge, 1: bandgap conversion |
| seq_done_i | input | 1 | Sequencer conversion finished (one cycle) |
| seq_count_i | input | 13 | Discharge count of the finished conversion |
| seq_ovf_i | input | 1 | Counter overflowed in the finished conversion |
| id_trim_o | output | 10 | Discharge-current code applied to the analog sink |
| gm_trim_o | output | 10 | Transconductance code applied to the analog input stage |
| busy_o | output | 1 | Calibration run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| fail_o | output | 1 | Last run ended with a code at a rail |

## Verification
The bench stands in for the sequencer with count models whose correct search results it derives by brute force over all 1024 codes. One model makes the full-scale target sit just below a region that overflows. Another pushes the bandgap count past 8191 on high codes. A design that trusted the wrapped count there would settle on a wrong code instead of 80 and 819. Targets of 0 and 500 drive the two loops to the upper and lower rail, which a design with a wrong fail rule or wrong trim direction would miss or flag wrongly. A second start pulse in mid-run and a check of the discharge code seen during bandgap conversions catch a design that restarts, or that feeds a stale discharge code into the second loop.

// File: rtl/dsc_trim_pkg.sv
package dsc_trim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID_REQ,
    ST_ID_WAIT,
    ST_GM_REQ,
    ST_GM_WAIT
  } trim_st_e;
endpackage

// File: rtl/dsc_trim_targets.sv
module dsc_trim_targets #(
  parameter int          CNT_W  = 13,
  parameter int unsigned FS_DEF = 4095,
  parameter int unsigned BG_DEF = 2457
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_we,
  input  logic             bg_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] fs_tgt,
  output logic [CNT_W-1:0] bg_tgt
);
  localparam logic [CNT_W-1:0] FS_RST = CNT_W'(FS_DEF);
  localparam logic [CNT_W-1:0] BG_RST = CNT_W'(BG_DEF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_tgt <= FS_RST;
      bg_tgt <= BG_RST;
    end else begin
      if (fs_we) fs_tgt <= wdata;
      if (bg_we) bg_tgt <= wdata;
    end
  end
endmodule

// File: rtl/dsc_trim_judge.sv
module dsc_trim_judge #(
  parameter int CNT_W = 13
) (
  input  logic             gm_phase,
  input  logic [CNT_W-1:0] count,
  input  logic             ovf,
  input  logic [CNT_W-1:0] fs_tgt,
  input  logic [CNT_W-1:0] bg_tgt,
  output logic             keep
);
  logic id_keep;
  logic gm_keep;

  // Discharge: long count means current too low -> keep the bit (more current).
  assign id_keep = ovf || (count >= fs_tgt);
  // Transconductor: long count means gm too high -> clear the bit.
  assign gm_keep = !ovf && (count <= bg_tgt);
  assign keep    = gm_phase ? gm_keep : id_keep;
endmodule

// File: rtl/dsc_trim_sar_step.sv
module dsc_trim_sar_step #(
  parameter int CODE_W = 10
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] mask,
  input  logic              keep,
  output logic [CODE_W-1:0] code_nxt,
  output logic [CODE_W-1:0] mask_nxt,
  output logic              last
);
  assign mask_nxt = mask >> 1;
  assign code_nxt = (keep ? code : (code & ~mask)) | mask_nxt;
  assign last     = mask[0];
endmodule

// File: rtl/dsc_trim_engine.sv
module dsc_trim_engine
  import dsc_trim_pkg::*;
#(
  parameter int          CODE_W = 10,
  parameter int          CNT_W  = 13,
  parameter int unsigned FS_DEF = 4095,
  parameter int unsigned BG_DEF = 2457
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start_i,
  input  logic              fs_tgt_we_i,
  input  logic              bg_tgt_we_i,
  input  logic [CNT_W-1:0]  tgt_data_i,
  output logic              seq_start_o,
  output logic              seq_mode_o,
  input  logic              seq_done_i,
  input  logic [CNT_W-1:0]  seq_count_i,
  input  logic              seq_ovf_i,
  output logic [CODE_W-1:0] id_trim_o,
  output logic [CODE_W-1:0] gm_trim_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  trim_st_e          st_q, st_d;
  logic [CODE_W-1:0] idw_q, idw_d, gmw_q, gmw_d;
  logic [CODE_W-1:0] idh_q, idh_d, gmh_q, gmh_d;
  logic [CODE_W-1:0] mask_q, mask_d;
  logic              done_d, fail_d;
  logic              work_en, hold_en;

  logic [CNT_W-1:0]  fs_tgt, bg_tgt;
  logic              gm_phase, keep, last;
  logic [CODE_W-1:0] step_code, step_mask, cur_code;

  dsc_trim_targets #(.CNT_W(CNT_W), .FS_DEF(FS_DEF), .BG_DEF(BG_DEF)) u_tgt (
    .clk    (clk),
    .rst_n  (rst_n),
    .fs_we  (fs_tgt_we_i),
    .bg_we  (bg_tgt_we_i),
    .wdata  (tgt_data_i),
    .fs_tgt (fs_tgt),
    .bg_tgt (bg_tgt)
  );

  assign gm_phase = (st_q == ST_GM_REQ) || (st_q == ST_GM_WAIT);
  assign cur_code = gm_phase ? gmw_q : idw_q;

  dsc_trim_judge #(.CNT_W(CNT_W)) u_judge (
    .gm_phase (gm_phase),
    .count    (seq_count_i),
    .ovf      (seq_ovf_i),
    .fs_tgt   (fs_tgt),
    .bg_tgt   (bg_tgt),
    .keep     (keep)
  );

  dsc_trim_sar_step #(.CODE_W(CODE_W)) u_step (
    .code     (cur_code),
    .mask     (mask_q),
    .keep     (keep),
    .code_nxt (step_code),
    .mask_nxt (step_mask),
    .last     (last)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    idw_d   = idw_q;
    gmw_d   = gmw_q;
    mask_d  = mask_q;
    idh_d   = idh_q;
    gmh_d   = gmh_q;
    fail_d  = fail_o;
    done_d  = 1'b0;
    work_en = 1'b0;
    hold_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cal_start_i) begin
        st_d    = ST_ID_REQ;
        idw_d   = MID;
        gmw_d   = MID;
        mask_d  = MID;
        fail_d  = 1'b0;
        work_en = 1'b1;
      end
      ST_ID_REQ: st_d = ST_ID_WAIT;
      ST_ID_WAIT: if (seq_done_i) begin
        work_en = 1'b1;
        idw_d   = step_code;
        mask_d  = last ? MID : step_mask;
        st_d    = last ? ST_GM_REQ : ST_ID_REQ;
      end
      ST_GM_REQ: st_d = ST_GM_WAIT;
      ST_GM_WAIT: if (seq_done_i) begin
        work_en = 1'b1;
        gmw_d   = step_code;
        mask_d  = step_mask;
        st_d    = ST_GM_REQ;
        if (last) begin
          st_d    = ST_IDLE;
          hold_en = 1'b1;
          idh_d   = idw_q;
          gmh_d   = step_code;
          done_d  = 1'b1;
          fail_d  = (&idw_q) || (~|idw_q) || (&step_code) || (~|step_code);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= done_d;
      fail_o <= fail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idw_q  <= MID;
      gmw_q  <= MID;
      mask_q <= MID;
    end else if (work_en) begin
      idw_q  <= idw_d;
      gmw_q  <= gmw_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idh_q <= MID;
      gmh_q <= MID;
    end else if (hold_en) begin
      idh_q <= idh_d;
      gmh_q <= gmh_d;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign seq_start_o = (st_q == ST_ID_REQ) || (st_q == ST_GM_REQ);
  assign seq_mode_o  = gm_phase;
  assign id_trim_o   = busy_o ? idw_q : idh_q;
  assign gm_trim_o   = gm_phase ? gmw_q : gmh_q;
endmodule

// File: rtl/dsc_trim_engine_chk.sv
module dsc_trim_engine_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_start_i,
  input logic              seq_start_o,
  input logic              seq_mode_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [CODE_W-1:0] id_trim_o,
  input logic [CODE_W-1:0] gm_trim_o
);
  p_busy_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(cal_start_i));

  p_done_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_req_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start_o |-> busy_o);

  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start_o |=> !seq_start_o);

  p_mode_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !seq_mode_o);

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |-> ($stable(id_trim_o) && $stable(gm_trim_o)));
endmodule

bind dsc_trim_engine dsc_trim_engine_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cal_start_i (cal_start_i),
  .seq_start_o (seq_start_o),
  .seq_mode_o  (seq_mode_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .id_trim_o   (id_trim_o),
  .gm_trim_o   (gm_trim_o)
);

// File: tb/test_dsc_trim_engine.sv
module test_dsc_trim_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_start_i = 1'b0;
  logic        fs_tgt_we_i = 1'b0;
  logic        bg_tgt_we_i = 1'b0;
  logic [12:0] tgt_data_i = '0;
  logic        seq_start_o, seq_mode_o;
  logic        seq_done_i = 1'b0;
  logic [12:0] seq_count_i = '0;
  logic        seq_ovf_i = 1'b0;
  logic [9:0]  id_trim_o, gm_trim_o;
  logic        busy_o, done_o, fail_o;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  bit finished = 0;

  int id_sel = 0, gm_sel = 0;
  int lat = 0, raw = 0;
  int n_starts = 0;
  bit seen_gm = 0, order_bad = 0;
  int id_in_gm = -1;

  always #4 clk = ~clk;

  dsc_trim_engine i_dsc_trim_engine (
    .clk(clk), .rst_n(rst_n), .cal_start_i(cal_start_i),
    .fs_tgt_we_i(fs_tgt_we_i), .bg_tgt_we_i(bg_tgt_we_i), .tgt_data_i(tgt_data_i),
    .seq_start_o(seq_start_o), .seq_mode_o(seq_mode_o), .seq_done_i(seq_done_i),
    .seq_count_i(seq_count_i), .seq_ovf_i(seq_ovf_i),
    .id_trim_o(id_trim_o), .gm_trim_o(gm_trim_o),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
  );

  // Count models of the analog side (raw count before 13-bit wrap)
  function automatic int id_raw(int c, int sel);
    int r;
    r = (sel == 0) ? 6000 - 3 * c : 9000 - 10 * c;
    return (r < 0) ? 0 : r;
  endfunction

  function automatic int gm_raw(int c, int sel);
    if (sel == 0) return 2 * c + 1000;
    if (sel == 1) return 4 * c;
    return 10 * c;
  endfunction

  // Expected search result: largest code meeting the keep rule, else 0 (R4)
  function automatic int exp_code(bit gm, int sel, int tgt);
    int best = 0;
    for (int c = 0; c < 1024; c++) begin
      if (!gm && id_raw(c, sel) >= tgt) best = c;
      if (gm && gm_raw(c, sel) <= 8191 && gm_raw(c, sel) <= tgt) best = c;
    end
    return best;
  endfunction

  // Sequencer model: fixed latency, done pulse with count and overflow
  always @(posedge clk) begin
    cyc++;
    seq_done_i <= (lat == 1);
    if (lat == 1) begin
      seq_count_i <= raw[12:0];
      seq_ovf_i   <= (raw > 8191);
    end
    if (lat != 0) lat--;
    if (seq_start_o) begin
      n_starts++;
      lat = 3;
      if (seq_mode_o) begin
        raw = gm_raw(int'(gm_trim_o), gm_sel);
        if (!seen_gm) begin
          seen_gm  = 1;
          id_in_gm = int'(id_trim_o);
        end
      end else begin
        raw = id_raw(int'(id_trim_o), id_sel);
        if (seen_gm) order_bad = 1;
      end
    end
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_tgt(bit gm, int val);
    @(negedge clk);
    tgt_data_i  = 13'(val);
    fs_tgt_we_i = !gm;
    bg_tgt_we_i = gm;
    @(negedge clk);
    fs_tgt_we_i = 0;
    bg_tgt_we_i = 0;
  endtask

  // One full run; restart_mid pulses cal_start again during the run (R11)
  task automatic run_cal(string name, int exp_id, int exp_gm, int exp_fail, bit restart_mid);
    int held_gm;
    int n;
    held_gm   = int'(gm_trim_o);
    n_starts  = 0;
    seen_gm   = 0;
    order_bad = 0;
    id_in_gm  = -1;
    @(negedge clk);
    cal_start_i = 1;
    @(negedge clk);
    cal_start_i = 0;
    check({name, " R2 busy after start"}, int'(busy_o), 1);
    check({name, " R10 fail cleared at start"}, int'(fail_o), 0);
    n = 0;
    while (!done_o && n < 3000) begin
      @(negedge clk);
      n++;
      if (n == 10 && restart_mid) cal_start_i = 1;
      if (n == 11) cal_start_i = 0;
      if (n == 20) check({name, " R9 gm held in discharge loop"}, int'(gm_trim_o), held_gm);
    end
    check({name, " R2 done pulse seen"}, int'(done_o), 1);
    check({name, " R2 busy low at done"}, int'(busy_o), 0);
    check({name, " R3 conversion count"}, n_starts, 20);
    check({name, " R3 mode order"}, int'(order_bad), 0);
    check({name, " R9 discharge code in gm loop"}, id_in_gm, exp_id);
    check({name, " R5 discharge code"}, int'(id_trim_o), exp_id);
    check({name, " R6 gm code"}, int'(gm_trim_o), exp_gm);
    check({name, " R10 fail"}, int'(fail_o), exp_fail);
    @(negedge clk);
    check({name, " R2 done one cycle"}, int'(done_o), 0);
    check({name, " R11 no extra run"}, int'(busy_o), 0);
  endtask

  task automatic t_reset;
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 fail", int'(fail_o), 0);
    check("R1 seq_start", int'(seq_start_o), 0);
    check("R1 id code", int'(id_trim_o), 512);
    check("R1 gm code", int'(gm_trim_o), 512);
  endtask

  task automatic t_defaults;
    id_sel = 0; gm_sel = 0;
    run_cal("R8 default targets", exp_code(0, 0, 4095), exp_code(1, 0, 2457), 0, 0);
  endtask

  task automatic t_overflow;
    write_tgt(0, 8191);
    write_tgt(1, 8191);
    id_sel = 1; gm_sel = 2;
    run_cal("R7 overflow", exp_code(0, 1, 8191), exp_code(1, 2, 8191), 0, 0);
    check("R7 discharge expected 80", exp_code(0, 1, 8191), 80);
    check("R7 gm expected 819", exp_code(1, 2, 8191), 819);
  endtask

  task automatic t_rails;
    write_tgt(0, 0);
    write_tgt(1, 500);
    id_sel = 0; gm_sel = 0;
    run_cal("R10 rails", 1023, 0, 1, 0);
  endtask

  task automatic t_hold_and_restart;
    int h_id, h_gm;
    write_tgt(0, 4095);
    write_tgt(1, 2457);
    id_sel = 1; gm_sel = 1;
    run_cal("R11 restart ignored", exp_code(0, 1, 4095), exp_code(1, 1, 2457), 0, 1);
    h_id = int'(id_trim_o);
    h_gm = int'(gm_trim_o);
    write_tgt(0, 100);
    repeat (20) @(negedge clk);
    check("R9 held id stable", int'(id_trim_o), h_id);
    check("R9 held gm stable", int'(gm_trim_o), h_gm);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_overflow();
    t_rails();
    t_hold_and_restart();
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule